// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character into one asynchronous serial frame per request. The frame format is chosen at run time. Its controls set the character length (5 to 8 bits) and an optional ninth slot. That slot carries either a hardware-generated parity bit or a caller-supplied extra bit. A further control selects a short or long stop period. The serial output idles high. A frame is a low start bit, then the data bits with the least-significant bit first, then the optional ninth slot, then the stop period driven high.

Timing comes from `tick_i`, a one-cycle strobe that an external baud generator pulses at sixteen times the bit rate. Because the tick is sixteen times the bit rate, a stop period can last one and a half bit times. The caller raises `start_i` for one cycle while `busy_o` is low. The block captures the byte and every format control on that edge, holds `busy_o` for the whole frame, and pulses `done_o` once the stop period ends.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `txd_o` is high, `busy_o` is low and `done_o` is low. `txd_o` stays high whenever `busy_o` is low.
- R2: `start_i` sampled high while idle sets `busy_o` on that clock edge and drives `txd_o` low for 16 ticks. A tick present in the accepting cycle does not count.
- R3: The data field lasts 16 ticks per bit and sends bits 0 upward of `data_i`. The number of bits sent is 5 + `len_i`, where `len_i` 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `data_i` above that length never appear on the line.
- R4: With `par_en_i` = 1, a 16-tick parity slot follows the last data bit. `par_type_i` = 0 selects even parity: the slot makes the count of ones in data plus slot even. `par_type_i` = 1 selects odd parity: the slot makes that count odd.
- R5: `par_type_i` = 2 drives the parity slot to 1. `par_type_i` = 3 drives it to 0.
- R6: With `par_en_i` = 0 and `xbit_en_i` = 1, a 16-tick slot carrying `xbit_i` follows the last data bit. With both enables at 0 the stop period follows the data directly.
- R7: With both `par_en_i` and `xbit_en_i` at 1, exactly one slot is sent and it carries the parity bit. `xbit_i` has no effect.
- R8: The stop period is high for 16 ticks when `long_stop_i` = 0. It is high for 32 ticks when `long_stop_i` = 1 and the length is 6, 7 or 8 bits.
- R9: With `long_stop_i` = 1 and 5-bit length, the stop period is 24 ticks.
- R10: All format controls and `data_i` are captured at the accepting edge. Changing them during a frame does not alter that frame.
- R11: `start_i` while `busy_o` is high is ignored. No further frame follows unless `start_i` is raised again while idle.
- R12: In the cycle after the clock edge that consumes the last stop tick, `done_o` is high and `busy_o` is low. `done_o` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at 16x bit rate |
| start_i | input | 1 | Frame request, accepted while idle |
| data_i | input | 8 | Character to send, bit 0 first |
| len_i | input | 2 | Data length minus 5 |
| par_en_i | input | 1 | Enable parity slot |
| par_type_i | input | 2 | 0 even, 1 odd, 2 mark, 3 space |
| xbit_en_i | input | 1 | Enable extra-bit slot (when parity off) |
| xbit_i | input | 1 | Value of the extra bit |
| long_stop_i | input | 1 | Long stop period select |
| txd_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench samples the line once per tick across whole frames and compares each sample against a frame it builds itself. It uses bytes with asymmetric patterns and set upper bits, so that a reversed bit order or a wrong truncation length shows up. Each parity type is paired with a data value whose ones count makes even and odd disagree. A parity-plus-extra request uses an extra bit opposite to the parity value, to show which one wins. Stop periods are measured at all three lengths, and a frame with its controls scrambled and `start_i` raised mid-flight shows that capture happens only at the start.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;

  typedef enum logic [1:0] {
    PAR_EVEN  = 2'd0,
    PAR_ODD   = 2'd1,
    PAR_MARK  = 2'd2,
    PAR_SPACE = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_SLOT,
    PH_STOP
  } phase_e;

  typedef struct packed {
    logic      par_en;
    par_mode_e par_mode;
    logic      xbit_en;
    logic      xbit;
    logic      long_stop;
  } fmt_t;

endpackage

// File: rtl/uart_tx_parity.sv
`timescale 1ns/1ps
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,   // already masked to frame length
  input  par_mode_e         mode_i,
  output logic              par_o
);

  logic odd_ones;
  assign odd_ones = ^data_i;

  always_comb begin
    unique case (mode_i)
      PAR_EVEN:  par_o = odd_ones;
      PAR_ODD:   par_o = ~odd_ones;
      PAR_MARK:  par_o = 1'b1;
      default:   par_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/uart_tx_tick_timer.sv
`timescale 1ns/1ps
module uart_tx_tick_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,   // ticks in period minus one
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = tick_i && (cnt_q == limit_i);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i); // R8

endmodule

// File: rtl/uart_frame_tx.sv
`timescale 1ns/1ps
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_LEN    = 5,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic [1:0] par_type_i,
  input  logic       xbit_en_i,
  input  logic       xbit_i,
  input  logic       long_stop_i,
  output logic       txd_o,
  output logic       busy_o,
  output logic       done_o
);

  localparam int IDX_W   = $clog2(DATA_W);
  localparam int CNT_W   = $clog2(2 * OVERSAMPLE);
  localparam logic [CNT_W-1:0] LIM_BIT  = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * OVERSAMPLE - 1);

  phase_e            phase_q;
  fmt_t              fmt_q;
  logic [1:0]        len_q;
  logic [DATA_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic              slot_q;
  logic              done_q;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] data_m;
  logic              par_bit;
  logic              accept;
  logic              period_end;
  logic [CNT_W-1:0]  limit;
  logic [IDX_W-1:0]  last_idx;
  fmt_t              fmt_in;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < (MIN_LEN + int'(len_i)));
  end
  assign data_m = data_i[DATA_W-1:0] & mask;

  assign fmt_in = '{par_en:    par_en_i,
                    par_mode:  par_mode_e'(par_type_i),
                    xbit_en:   xbit_en_i,
                    xbit:      xbit_i,
                    long_stop: long_stop_i};

  uart_tx_parity #(.DATA_W(DATA_W)) i_parity (
    .data_i (data_m),
    .mode_i (fmt_in.par_mode),
    .par_o  (par_bit)
  );

  assign accept   = (phase_q == PH_IDLE) && start_i;
  assign last_idx = IDX_W'(MIN_LEN - 1 + int'(len_q));

  always_comb begin
    limit = LIM_BIT;
    if (phase_q == PH_STOP && fmt_q.long_stop)
      limit = (len_q == 2'd0) ? LIM_HALF : LIM_TWO;
  end

  uart_tx_tick_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   ((phase_q == PH_IDLE) || period_end),
    .tick_i  (tick_i),
    .limit_i (limit),
    .last_o  (period_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      fmt_q   <= '0;
      len_q   <= '0;
      shreg_q <= '0;
      idx_q   <= '0;
      slot_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        phase_q <= PH_START;
        fmt_q   <= fmt_in;
        len_q   <= len_i;
        shreg_q <= data_m;
        idx_q   <= '0;
        // parity wins over the extra bit
        slot_q  <= par_en_i ? par_bit : xbit_i;
      end else if (period_end && phase_q != PH_IDLE) begin
        unique case (phase_q)
          PH_START: phase_q <= PH_DATA;
          PH_DATA: begin
            shreg_q <= shreg_q >> 1;
            idx_q   <= idx_q + 1'b1;
            if (idx_q == last_idx)
              phase_q <= (fmt_q.par_en || fmt_q.xbit_en) ? PH_SLOT : PH_STOP;
          end
          PH_SLOT: phase_q <= PH_STOP;
          default: begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        endcase
      end
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_START: txd_o = 1'b0;
      PH_DATA:  txd_o = shreg_q[0];
      PH_SLOT:  txd_o = slot_q;
      default:  txd_o = 1'b1;
    endcase
  end

  assign busy_o = (phase_q != PH_IDLE);
  assign done_o = done_q;

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o); // R1
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o); // R2
  AST_FMT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(fmt_q) && $stable(len_q) && $stable(slot_q)); // R10
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !period_end |=> busy_o); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_DONE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R12

endmodule

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/1ps
module test_uart_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       start = 1'b0;
  logic [7:0] data = '0;
  logic [1:0] len = '0;
  logic       par_en = 1'b0;
  logic [1:0] par_type = '0;
  logic       xbit_en = 1'b0;
  logic       xbit = 1'b0;
  logic       long_stop = 1'b0;
  logic       txd, busy, done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [1:0] div_q;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end
  assign tick = (div_q == 2'd3);

  uart_frame_tx i_uart_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start),
    .data_i(data), .len_i(len), .par_en_i(par_en), .par_type_i(par_type),
    .xbit_en_i(xbit_en), .xbit_i(xbit), .long_stop_i(long_stop),
    .txd_o(txd), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(txd == 1'b1, "R1 idle line", int'(txd), 1);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
  endtask

  // Sends one frame and checks it tick by tick; scramble=1 disturbs inputs mid-frame.
  task automatic run_frame(input logic [7:0] d, input logic [1:0] l, input bit pe,
                           input logic [1:0] pt, input bit xe, input bit xb,
                           input bit ls, input bit scramble, input string tag);
    int n, slot, stop_t, total, bad_j, bad_a, bad_e;
    logic slot_v, ones, e;
    n = 5 + int'(l);
    ones = 1'b0;
    for (int i = 0; i < n; i++) ones ^= d[i];
    case (pt)
      2'd0: slot_v = ones;
      2'd1: slot_v = ~ones;
      2'd2: slot_v = 1'b1;
      default: slot_v = 1'b0;
    endcase
    if (!pe) slot_v = xb;
    slot = (pe || xe) ? 1 : 0;
    stop_t = !ls ? 16 : (n == 5 ? 24 : 32);
    total = 16 * (1 + n + slot) + stop_t;

    @(negedge clk);
    data = d; len = l; par_en = pe; par_type = pt;
    xbit_en = xe; xbit = xb; long_stop = ls; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {"R2 busy on accept ", tag}, int'(busy), 1);

    bad_j = -1; bad_a = 0; bad_e = 0;
    for (int j = 0; j < total; j++) begin
      while (!tick) @(negedge clk);
      if (scramble && j == 40) begin
        data = ~d; len = ~l; par_en = ~pe; par_type = ~pt;
        xbit_en = ~xe; xbit = ~xb; long_stop = ~ls; start = 1'b1;
      end
      if (scramble && j == 41) start = 1'b0;
      if (j / 16 == 0)                       e = 1'b0;
      else if (j / 16 <= n)                  e = d[j / 16 - 1];
      else if (j / 16 == n + 1 && slot == 1) e = slot_v;
      else                                   e = 1'b1;
      if (txd !== e && bad_j < 0) begin
        bad_j = j; bad_a = int'(txd); bad_e = int'(e);
      end
      if (j == total - 1 && busy !== 1'b1 && bad_j < 0) begin
        bad_j = j; bad_a = 0; bad_e = 1;
      end
      @(negedge clk);
    end
    chk(bad_j < 0, {tag, " line per tick"}, bad_a, bad_e);
    if (bad_j >= 0) $display("  first mismatch at tick %0d", bad_j);
    chk(done == 1'b1 && busy == 1'b0, {"R12 done after stop ", tag},
        int'({done, busy}), 2);
    @(negedge clk);
    chk(done == 1'b0, {"R12 done one cycle ", tag}, int'(done), 0);
  endtask

  task automatic t_no_restart();
    repeat (200) begin
      @(negedge clk);
      if (busy || !txd) break;
    end
    chk(busy == 1'b0 && txd == 1'b1, "R11 no frame after ignored start",
        int'({busy, txd}), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_frame(8'hB4, 2'd3, 0, 2'd0, 0, 0, 0, 0, "R3 R8 8-bit plain");
    run_frame(8'hED, 2'd0, 0, 2'd0, 0, 0, 0, 0, "R3 5-bit masked");
    run_frame(8'hC5, 2'd1, 1, 2'd0, 0, 0, 0, 0, "R4 6-bit even");
    run_frame(8'h4B, 2'd2, 1, 2'd1, 0, 0, 0, 0, "R4 7-bit odd");
    run_frame(8'h00, 2'd3, 1, 2'd2, 0, 0, 0, 0, "R5 mark");
    run_frame(8'h1F, 2'd0, 1, 2'd3, 0, 0, 0, 0, "R5 space");
    run_frame(8'h96, 2'd3, 0, 2'd0, 1, 1, 0, 0, "R6 extra one");
    run_frame(8'h3F, 2'd1, 0, 2'd0, 1, 0, 0, 0, "R6 extra zero");
    run_frame(8'h07, 2'd3, 1, 2'd0, 1, 0, 0, 0, "R7 parity over extra");
    run_frame(8'hA5, 2'd3, 0, 2'd0, 0, 0, 1, 0, "R8 long 8-bit");
    run_frame(8'h2A, 2'd1, 1, 2'd1, 0, 0, 1, 0, "R8 long 6-bit");
    run_frame(8'h15, 2'd0, 0, 2'd0, 0, 0, 1, 0, "R9 long 5-bit");
    run_frame(8'h69, 2'd2, 1, 2'd0, 0, 0, 0, 1, "R10 R11 scrambled");
    t_no_restart();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule